// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands a command to an embedded controller and collects the result. The host writes up to four payload words into a write buffer, then writes a packed command word. That write marks the mailbox busy and sends a one-cycle doorbell to the controller. The controller reads the decoded command fields and the payload words through its own side ports. It fills a four-word read buffer and then strobes done, with an error flag and an 8-bit error code.

The host either polls the status word until busy drops, or asks in the command word for a completion interrupt. That interrupt is a single-cycle pulse and needs no clearing. While a command is in flight, the command register and the write buffer are locked against host writes, so a stray access cannot alter the request the controller is working on.

The host port is a simple single-cycle word port with combinational read data. A byte-mode qualifier selects one byte of the addressed word, returned zero-extended.

Top module: `mbox_ipc_top`

## Requirements
- R1: After reset, busy and error are clear, the doorbell and host interrupt outputs are low, and the status word reads as the initiator id in bits [15:8] with all other bits zero.
- R2: A host write to offset 0x00 while idle sets busy, visible from the next cycle. It raises the doorbell for exactly one cycle. It presents opcode (bits [7:0]), sub-command id (bits [15:12]) and payload size in bytes (bits [23:16]) to the controller. Status bits [7:4] echo the sub-command id.
- R3: While busy, host writes to the command register or to the write buffer are ignored.
- R4: Word writes at offsets 0x80, 0x84, 0x88 and 0x8C load write-buffer words 0 to 3, which the controller reads by index. Host reads of the write buffer and of the command register return zero.
- R5: The controller loads read-buffer words 0 to 3 by index. The host reads them as words at 0x90 + 4k, or as single bytes at 0x90 to 0x9F (little-endian, byte 0 in bits [7:0]), zero-extended.
- R6: A done strobe while busy clears busy and loads status bit 1 (error) and bits [23:16] (error code). A new accepted command clears both.
- R7: A host interrupt pulse of exactly one cycle follows an accepted done strobe if, and only if, bit 8 of the last accepted command was set.
- R8: Reads of unmapped offsets return zero. Host writes to the status word or to the read buffer change nothing.
- R9: A done strobe while idle is ignored: no interrupt, and the status word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host byte address |
| hostWrData | input | 32 | Host write data |
| hostByteRd | input | 1 | 1: read returns the addressed byte zero-extended |
| hostRdData | output | 32 | Host read data (combinational) |
| hostIrq | output | 1 | Completion interrupt pulse to host |
| ctrlDoorbell | output | 1 | One-cycle pulse to controller on accepted command |
| ctrlOpcode | output | 8 | Latched command opcode |
| ctrlSubCmd | output | 4 | Latched sub-command id |
| ctrlSize | output | 8 | Latched payload size in bytes |
| ctrlWbufIdx | input | 2 | Write-buffer word index read by controller |
| ctrlWbufData | output | 32 | Selected write-buffer word |
| ctrlRbufWe | input | 1 | Controller read-buffer write strobe |
| ctrlRbufIdx | input | 2 | Read-buffer word index written |
| ctrlRbufData | input | 32 | Read-buffer word data |
| ctrlDone | input | 1 | Command finished strobe |
| ctrlErr | input | 1 | Error flag loaded with done |
| ctrlErrCode | input | 8 | Error code loaded with done |

## Verification
The bench builds the block with its default parameters: a 32-bit word, four buffer words and an initiator id of 0x5A. With these values the status word has a known constant field, and every buffer word and every read-buffer byte lane can be reached with a few accesses. A table of host accesses covers decode, the zero-return holes and ignored writes. Directed sequences then drive a full command with an error completion and an interrupt, writes attempted while busy, a done strobe while idle, and a second command without the interrupt bit.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic cmdLoad;   // accepted command write
    logic wbufLoad;  // accepted write-buffer word write
    logic doneLoad;  // accepted controller completion
  } ctlStrobes_t;

  localparam logic [7:0] OFS_CMD    = 8'h00;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_WBUF   = 8'h80;
  localparam logic [7:0] OFS_RBUF   = 8'h90;

  localparam int CMD_IOC_BIT = 8;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostIocBit,
  input  logic              ctrlDone,
  output ctlStrobes_t       strobes,
  output logic              busy,
  output logic              doorbell,
  output logic              irq
);
  localparam int BUF_BYTES = BUF_WORDS * 4;

  logic busyQ, iocQ, doorbellQ, irqQ;
  logic cmdHit, wbufHit, cmdAcc, doneAcc;

  always_comb begin
    cmdHit  = (hostAddr == ADDR_W'(OFS_CMD));
    wbufHit = (hostAddr >= ADDR_W'(OFS_WBUF)) &&
              (hostAddr <  ADDR_W'(OFS_WBUF) + ADDR_W'(BUF_BYTES)) &&
              (hostAddr[1:0] == 2'b00);
    cmdAcc  = hostWrEn && cmdHit && !busyQ;
    doneAcc = ctrlDone && busyQ;
    strobes.cmdLoad  = cmdAcc;
    strobes.wbufLoad = hostWrEn && wbufHit && !busyQ;
    strobes.doneLoad = doneAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      iocQ      <= 1'b0;
      doorbellQ <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      doorbellQ <= cmdAcc;
      irqQ      <= doneAcc && iocQ;
      if (cmdAcc) begin
        busyQ <= 1'b1;
        iocQ  <= hostIocBit;
      end else if (doneAcc) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy     = busyQ;
  assign doorbell = doorbellQ;
  assign irq      = irqQ;
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 32,
  parameter int          BUF_WORDS    = 4,
  parameter logic [7:0]  INITIATOR_ID = 8'h5A
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strobes,
  input  logic                         busy,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [DATA_W-1:0]            hostWrData,
  input  logic                         hostByteRd,
  output logic [DATA_W-1:0]            hostRdData,
  output logic [7:0]                   opcode,
  output logic [3:0]                   subCmd,
  output logic [7:0]                   sizeBytes,
  input  logic [$clog2(BUF_WORDS)-1:0] wbufIdx,
  output logic [DATA_W-1:0]            wbufData,
  input  logic                         rbufWe,
  input  logic [$clog2(BUF_WORDS)-1:0] rbufIdx,
  input  logic [DATA_W-1:0]            rbufData,
  input  logic                         doneErr,
  input  logic [7:0]                   doneCode
);
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int BYTES_W   = DATA_W / 8;
  localparam int LANE_W    = $clog2(BYTES_W);
  localparam int BUF_BYTES = BUF_WORDS * BYTES_W;

  logic [7:0]        opcodeQ, sizeQ, errCodeQ;
  logic [3:0]        subQ;
  logic              errQ;
  logic [DATA_W-1:0] wbufQ [BUF_WORDS];
  logic [DATA_W-1:0] rbufQ [BUF_WORDS];
  logic [IDX_W-1:0]  hostIdx;

  assign hostIdx = hostAddr[LANE_W +: IDX_W];

  // Command fields and completion status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ  <= '0;
      subQ     <= '0;
      sizeQ    <= '0;
      errQ     <= 1'b0;
      errCodeQ <= '0;
    end else if (strobes.cmdLoad) begin
      opcodeQ  <= hostWrData[7:0];
      subQ     <= hostWrData[15:12];
      sizeQ    <= hostWrData[23:16];
      errQ     <= 1'b0;
      errCodeQ <= '0;
    end else if (strobes.doneLoad) begin
      errQ     <= doneErr;
      errCodeQ <= doneCode;
    end
  end

  // Buffer storage, one register per word
  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wbufQ[w] <= '0;
        rbufQ[w] <= '0;
      end else begin
        if (strobes.wbufLoad && hostIdx == IDX_W'(w)) wbufQ[w] <= hostWrData;
        if (rbufWe && rbufIdx == IDX_W'(w))           rbufQ[w] <= rbufData;
      end
    end
  end

  // Host read mux
  logic [DATA_W-1:0] wordSel;
  logic [ADDR_W-1:0] wordAddr;
  logic [LANE_W-1:0] lane;

  always_comb begin
    wordAddr = {hostAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    lane     = hostAddr[LANE_W-1:0];
    wordSel  = '0;
    if (wordAddr == ADDR_W'(OFS_STATUS)) begin
      wordSel        = '0;
      wordSel[0]     = busy;
      wordSel[1]     = errQ;
      wordSel[7:4]   = subQ;
      wordSel[15:8]  = INITIATOR_ID;
      wordSel[23:16] = errCodeQ;
    end else if (wordAddr >= ADDR_W'(OFS_RBUF) &&
                 wordAddr <  ADDR_W'(OFS_RBUF) + ADDR_W'(BUF_BYTES)) begin
      wordSel = rbufQ[hostIdx];
    end
    if (hostByteRd) hostRdData = DATA_W'(wordSel[lane*8 +: 8]);
    else            hostRdData = wordSel;
  end

  assign opcode    = opcodeQ;
  assign subCmd    = subQ;
  assign sizeBytes = sizeQ;
  assign wbufData  = wbufQ[wbufIdx];
endmodule

// File: rtl/mbox_ipc_top.sv
module mbox_ipc_top
  import mbox_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         DATA_W       = 32,
  parameter int         BUF_WORDS    = 4,
  parameter logic [7:0] INITIATOR_ID = 8'h5A
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hostWrEn,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [DATA_W-1:0]            hostWrData,
  input  logic                         hostByteRd,
  output logic [DATA_W-1:0]            hostRdData,
  output logic                         hostIrq,
  output logic                         ctrlDoorbell,
  output logic [7:0]                   ctrlOpcode,
  output logic [3:0]                   ctrlSubCmd,
  output logic [7:0]                   ctrlSize,
  input  logic [$clog2(BUF_WORDS)-1:0] ctrlWbufIdx,
  output logic [DATA_W-1:0]            ctrlWbufData,
  input  logic                         ctrlRbufWe,
  input  logic [$clog2(BUF_WORDS)-1:0] ctrlRbufIdx,
  input  logic [DATA_W-1:0]            ctrlRbufData,
  input  logic                         ctrlDone,
  input  logic                         ctrlErr,
  input  logic [7:0]                   ctrlErrCode
);
  ctlStrobes_t strobes;
  logic        busyW;

  mbox_ctrl #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostIocBit(hostWrData[CMD_IOC_BIT]),
    .ctrlDone(ctrlDone),
    .strobes(strobes), .busy(busyW),
    .doorbell(ctrlDoorbell), .irq(hostIrq)
  );

  mbox_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BUF_WORDS(BUF_WORDS), .INITIATOR_ID(INITIATOR_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .busy(busyW),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostByteRd(hostByteRd),
    .hostRdData(hostRdData),
    .opcode(ctrlOpcode), .subCmd(ctrlSubCmd), .sizeBytes(ctrlSize),
    .wbufIdx(ctrlWbufIdx), .wbufData(ctrlWbufData),
    .rbufWe(ctrlRbufWe), .rbufIdx(ctrlRbufIdx), .rbufData(ctrlRbufData),
    .doneErr(ctrlErr), .doneCode(ctrlErrCode)
  );
endmodule

// File: rtl/mbox_ipc_chk.sv
module mbox_ipc_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              ctrlDone,
  input logic              busy,
  input logic              doorbell,
  input logic              hostIrq,
  input logic [7:0]        opcode
);
  a_r2_busy_on_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == '0 && !busy) |=> busy);

  a_r2_doorbell_single: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |=> !doorbell);

  a_r2_doorbell_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> doorbell);

  a_r3_opcode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(opcode));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlDone && busy) |=> !busy);

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctrlDone) |=> busy);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq);

  a_r9_idle_done: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlDone && !busy) |=> !hostIrq);
endmodule

bind mbox_ipc_top mbox_ipc_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .ctrlDone(ctrlDone), .busy(busyW), .doorbell(ctrlDoorbell),
  .hostIrq(hostIrq), .opcode(ctrlOpcode)
);

// File: tb/mbox_ipc_tb.sv
module mbox_ipc_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic        hostByteRd = 1'b0;
  logic [31:0] hostRdData;
  logic        hostIrq, ctrlDoorbell;
  logic [7:0]  ctrlOpcode, ctrlSize;
  logic [3:0]  ctrlSubCmd;
  logic [1:0]  ctrlWbufIdx = '0;
  logic [31:0] ctrlWbufData;
  logic        ctrlRbufWe = 1'b0;
  logic [1:0]  ctrlRbufIdx = '0;
  logic [31:0] ctrlRbufData = '0;
  logic        ctrlDone = 1'b0, ctrlErr = 1'b0;
  logic [7:0]  ctrlErrCode = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  mbox_ipc_top dut_i (.*);

  // kind: 0 = word write, 1 = word read check, 2 = byte read check
  localparam int NVEC = 12;
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd1, 8'h04, 32'h0000_5A00},  // R1 reset status
    {2'd0, 8'h80, 32'h1122_3344},  // R4
    {2'd0, 8'h84, 32'h5566_7788},  // R4
    {2'd0, 8'h88, 32'h99AA_BBCC},  // R4
    {2'd0, 8'h8C, 32'hDDEE_FF00},  // R4
    {2'd1, 8'h80, 32'h0000_0000},  // R4 wbuf reads zero
    {2'd1, 8'h00, 32'h0000_0000},  // R4 cmd reads zero
    {2'd1, 8'h40, 32'h0000_0000},  // R8 unmapped
    {2'd0, 8'h04, 32'hFFFF_FFFF},  // R8 write to status
    {2'd1, 8'h04, 32'h0000_5A00},  // R8 status unchanged
    {2'd2, 8'h91, 32'h0000_0000},  // R5 reset rbuf byte
    {2'd2, 8'h05, 32'h0000_005A}   // R5 byte lane of status
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, input logic byteMode, output logic [31:0] d);
    hostAddr = a; hostByteRd = byteMode;
    #1 d = hostRdData;
    hostByteRd = 1'b0;
  endtask

  task automatic ctrlFill(input logic [1:0] idx, input logic [31:0] d);
    ctrlRbufIdx = idx; ctrlRbufData = d; ctrlRbufWe = 1'b1;
    @(negedge clk);
    ctrlRbufWe = 1'b0;
  endtask

  task automatic ctrlFinish(input logic err, input logic [7:0] code);
    ctrlErr = err; ctrlErrCode = code; ctrlDone = 1'b1;
    @(negedge clk);
    ctrlDone = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'b0, hostIrq}, 32'd0);
    check("R1 doorbell", {31'b0, ctrlDoorbell}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][41:40])
        2'd0: hostWrite(VEC[i][39:32], VEC[i][31:0]);
        default: begin
          hostRead(VEC[i][39:32], VEC[i][41:40] == 2'd2, rd);
          check($sformatf("vec %0d (R1/R4/R5/R8)", i), rd, VEC[i][31:0]);
          @(negedge clk);
        end
      endcase
    end

    // R4 controller view of the write buffer
    for (int k = 0; k < 4; k++) begin
      ctrlWbufIdx = 2'(k);
      #1;
      case (k)
        0: check("R4 wbuf0", ctrlWbufData, 32'h1122_3344);
        1: check("R4 wbuf1", ctrlWbufData, 32'h5566_7788);
        2: check("R4 wbuf2", ctrlWbufData, 32'h99AA_BBCC);
        default: check("R4 wbuf3", ctrlWbufData, 32'hDDEE_FF00);
      endcase
    end
    @(negedge clk);

    // R2 command with interrupt request: opcode A5, sub 3, size 8
    hostWrite(8'h00, 32'h0008_31A5);
    check("R2 doorbell", {31'b0, ctrlDoorbell}, 32'd1);
    check("R2 fields", {12'b0, ctrlSize, ctrlSubCmd, ctrlOpcode}, {12'b0, 8'd8, 4'd3, 8'hA5});
    hostRead(8'h04, 1'b0, rd);
    check("R2 busy status", rd, 32'h0000_5A31);
    @(negedge clk);
    check("R2 doorbell single", {31'b0, ctrlDoorbell}, 32'd0);

    // R3 writes while busy
    hostWrite(8'h00, 32'h0000_02FF);
    hostWrite(8'h80, 32'h0000_0000);
    ctrlWbufIdx = 2'd0;
    #1;
    check("R3 opcode kept", {24'b0, ctrlOpcode}, 32'h0000_00A5);
    check("R3 wbuf kept", ctrlWbufData, 32'h1122_3344);
    check("R3 no doorbell", {31'b0, ctrlDoorbell}, 32'd0);
    @(negedge clk);

    // R5 controller fills read buffer
    ctrlFill(2'd0, 32'hCAFE_F00D);
    ctrlFill(2'd3, 32'h0102_0304);
    hostRead(8'h90, 1'b0, rd);  check("R5 word0", rd, 32'hCAFE_F00D);
    hostRead(8'h9F, 1'b1, rd);  check("R5 byte 0x9F", rd, 32'h0000_0001);
    hostRead(8'h91, 1'b1, rd);  check("R5 byte 0x91", rd, 32'h0000_00F0);
    @(negedge clk);
    hostWrite(8'h90, 32'h0);
    hostRead(8'h90, 1'b0, rd);  check("R8 rbuf write ignored", rd, 32'hCAFE_F00D);
    @(negedge clk);

    // R6/R7 completion with error
    ctrlFinish(1'b1, 8'h42);
    check("R7 irq pulse", {31'b0, hostIrq}, 32'd1);
    hostRead(8'h04, 1'b0, rd);
    check("R6 error status", rd, 32'h0042_5A32);
    @(negedge clk);
    check("R7 irq single", {31'b0, hostIrq}, 32'd0);

    // R9 done while idle
    ctrlFinish(1'b0, 8'h00);
    check("R9 no irq", {31'b0, hostIrq}, 32'd0);
    hostRead(8'h04, 1'b0, rd);
    check("R9 status kept", rd, 32'h0042_5A32);
    @(negedge clk);

    // R6/R7 second command, no interrupt requested
    hostWrite(8'h00, 32'h0004_0010);
    hostRead(8'h04, 1'b0, rd);
    check("R6 error cleared", rd, 32'h0000_5A01);
    @(negedge clk);
    ctrlFinish(1'b0, 8'h00);
    check("R7 no irq without request", {31'b0, hostIrq}, 32'd0);
    hostRead(8'h04, 1'b0, rd);
    check("R6 clean done", rd, 32'h0000_5A00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule